// File: doc/BRIEF.md
# Beam-Synchronised Display Coprocessor

This block is a small list processor that walks a program of two-word instructions held in memory and writes display registers at chosen points of the video raster. It fetches each 16-bit word through a request/grant read port. It requests the bus only on every other cycle, so a fully granted instruction occupies four cycles. Three operations exist. A register move drives an 8-bit register word address and a 16-bit data word onto a write output. A wait stalls fetching until the beam reaches a position. A conditional skip steps over the following instruction when that position has already been reached.

A position is compared as one number: the vertical count in the upper bits and the upper seven bits of the horizontal count below it. Each vertical bit except the top one, and each horizontal bit, has an enable. Disabled bits are zero on both sides of the compare. An optional condition can also require the blitter-finished input. The program counter is reloaded from one of two host-written location registers. A reload happens on a host strobe, on a register move to one of two strobe addresses, or, for the first location, on the vertical-blank strobe. Register moves below a protected address limit stop the processor unless the host has set the danger bit.

Top module: `beam_coproc`

## Requirements
- R1: After reset the processor is halted. It raises neither `mem_req` nor `reg_we` until a jump strobe or `vblank` arrives.
- R2: On a reload the location value is used with bit 0 cleared. Each granted word advances the fetch address by 2. `mem_req` is high only on alternate cycles counted from reset, and `mem_addr` holds its value until a grant or a reload.
- R3: A first word with bit 0 = 0 is a move to register word address `w1[8:1]`. In the cycle after the second word is granted, `reg_we` is high for one cycle with that address and the second word as data.
- R4: A first word with bit 0 = 1 and a second word with bit 0 = 0 is a wait. No further word is requested until the compare holds. Position fields: `w1[15:8]` is V7..V0 and `w1[7:1]` is H8..H2. Enable fields: `w2[14:8]` is VE6..VE0 and `w2[7:1]` is HE8..HE2.
- R5: The compare is `{V7, V6..V0 & VE, H8..H2 & HE}` of the beam taken as greater than or equal to the same form of the programmed position. V7 always takes part.
- R6: When `w2[15]` = 0, the compare also needs `blit_done` = 1. When `w2[15]` = 1, `blit_done` is ignored.
- R7: A first word with bit 0 = 1 and a second word with bit 0 = 1 is a skip. If the compare holds when the second word is granted, the next two words are neither fetched nor executed. Otherwise execution continues with them.
- R8: `jmp_strobe[0]` or `vblank` loads location 1 and `jmp_strobe[1]` loads location 2, then fetching restarts. `vblank` and `jmp_strobe[0]` take precedence over `jmp_strobe[1]`.
- R9: A move to word address `JMP1_WADDR` (default 0x44) or `JMP2_WADDR` (default 0x45) still drives the write output and also reloads the program counter from location 1 or 2.
- R10: A move to a word address below `PROT_LIMIT` (default 0x20) while the danger bit is 0 produces no write. The processor stops requesting until the next reload. With the danger bit set, the write takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_req | output | 1 | Word read request |
| mem_addr | output | ADDR_W | Byte address of the requested word, always even |
| mem_gnt | input | 1 | Grant; the read completes in a cycle where request and grant are both high |
| mem_rdata | input | 16 | Read word, valid with the grant |
| reg_we | output | 1 | Register write pulse |
| reg_addr | output | 8 | Register word address |
| reg_wdata | output | 16 | Register write data |
| beam_v | input | 8 | Vertical beam count |
| beam_h | input | 9 | Horizontal beam count |
| blit_done | input | 1 | Blitter-finished condition |
| vblank | input | 1 | Start-of-vertical-blank strobe |
| loc_we | input | 2 | Host write enables for locations 1 (bit 0) and 2 (bit 1) |
| loc_wdata | input | ADDR_W | Host location write value |
| jmp_strobe | input | 2 | Host jump strobes to location 1 (bit 0) and 2 (bit 1) |
| ctl_we | input | 1 | Host write enable for the danger bit |
| ctl_danger | input | 1 | New danger bit value |

## Verification
The bench builds the block with its default parameters: 18-bit addresses, a protected limit of 0x20 and strobe addresses 0x44 and 0x45. Its programs therefore sit in the low two kilobytes and can reach both the protected range and the strobe addresses. A stalling grant pattern during the first program moves fetch completion onto uneven cycles against the fixed request rhythm. The beam sweeps continuously, so waits end and skips decide on live positions that include the unmaskable top vertical bit.

// File: rtl/beam_coproc_pkg.sv
package beam_coproc_pkg;

  typedef enum logic [1:0] {
    ST_HALT   = 2'd0,
    ST_FETCH1 = 2'd1,
    ST_FETCH2 = 2'd2,
    ST_WAIT   = 2'd3
  } seq_state_e;

  // Masked beam position: top vertical bit always kept, the rest gated by enables.
  function automatic logic [14:0] masked_pos(input logic [7:0] v, input logic [8:0] h,
                                             input logic [15:0] en);
    masked_pos = {v[7], v[6:0] & en[14:8], h[8:2] & en[7:1]};
  endfunction

  // Beam reached the programmed point in w1, with enables and blitter flag in w2.
  function automatic logic beam_reached(input logic [7:0] bv, input logic [8:0] bh,
                                        input logic [15:0] w1, input logic [15:0] w2,
                                        input logic blit_done);
    logic [8:0] prog_h;
    prog_h = {w1[7:1], 2'b00};
    beam_reached = (masked_pos(bv, bh, w2) >= masked_pos(w1[15:8], prog_h, w2))
                   && (w2[15] || blit_done);
  endfunction

endpackage

// File: rtl/coproc_locs.sv
module coproc_locs #(
  parameter int ADDR_W = 18,
  parameter int N_LOC  = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [N_LOC-1:0]             loc_we,
  input  logic [ADDR_W-1:0]            loc_wdata,
  input  logic                         ctl_we,
  input  logic                         ctl_danger,
  output logic [N_LOC-1:0][ADDR_W-1:0] loc_o,
  output logic                         danger_o
);

  for (genvar gi = 0; gi < N_LOC; gi++) begin : g_loc
    logic [ADDR_W-1:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n)          q <= '0;
      else if (loc_we[gi]) q <= loc_wdata;
    end
    assign loc_o[gi] = q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      danger_o <= 1'b0;
    else if (ctl_we) danger_o <= ctl_danger;
  end

endmodule

// File: rtl/coproc_beam_cmp.sv
module coproc_beam_cmp
  import beam_coproc_pkg::*;
(
  input  logic [7:0]  beam_v,
  input  logic [8:0]  beam_h,
  input  logic [15:0] w1,
  input  logic [15:0] w2,
  input  logic        blit_done,
  output logic        hit
);
  assign hit = beam_reached(beam_v, beam_h, w1, w2, blit_done);
endmodule

// File: rtl/coproc_seq.sv
module coproc_seq
  import beam_coproc_pkg::*;
#(
  parameter int         ADDR_W     = 18,
  parameter logic [7:0] PROT_LIMIT = 8'h20,
  parameter logic [7:0] JMP1_WADDR = 8'h44,
  parameter logic [7:0] JMP2_WADDR = 8'h45
) (
  input  logic                  clk,
  input  logic                  rst_n,
  output logic                  mem_req,
  output logic [ADDR_W-1:0]     mem_addr,
  input  logic                  mem_gnt,
  input  logic [15:0]           mem_rdata,
  output logic                  reg_we,
  output logic [7:0]            reg_addr,
  output logic [15:0]           reg_wdata,
  input  logic [1:0][ADDR_W-1:0] loc,
  input  logic                  danger,
  input  logic                  vblank,
  input  logic [1:0]            jmp_strobe,
  input  logic                  blit_done,
  input  logic                  skip_hit,
  input  logic                  wait_hit,
  output logic [15:0]           ir1_o,
  output logic [15:0]           ir2_o
);

  localparam logic [ADDR_W-1:0] WORD_STEP  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] SKIP_STEP  = ADDR_W'(6);
  localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(1);

  seq_state_e        st;
  logic              slot;
  logic [ADDR_W-1:0] pc;
  logic [15:0]       ir1, ir2;

  // Named events
  wire take          = mem_req && mem_gnt;
  wire redirect      = vblank || jmp_strobe[0] || jmp_strobe[1];
  wire [ADDR_W-1:0] redirect_pc = ((vblank || jmp_strobe[0]) ? loc[0] : loc[1]) & ALIGN_MASK;
  wire is_move       = ~ir1[0];
  wire [7:0] mv_addr = ir1[8:1];
  wire mv_blocked    = (mv_addr < PROT_LIMIT) && !danger;
  wire mv_jump1      = (mv_addr == JMP1_WADDR);
  wire mv_jump2      = (mv_addr == JMP2_WADDR);
  wire is_wait       = ~mem_rdata[0];

  assign mem_req  = slot && (st == ST_FETCH1 || st == ST_FETCH2);
  assign mem_addr = pc;
  assign ir1_o    = ir1;
  assign ir2_o    = ir2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_HALT;
      slot      <= 1'b0;
      pc        <= '0;
      ir1       <= '0;
      ir2       <= '0;
      reg_we    <= 1'b0;
      reg_addr  <= '0;
      reg_wdata <= '0;
    end else begin
      slot   <= ~slot;
      reg_we <= 1'b0;
      if (redirect) begin
        pc <= redirect_pc;
        st <= ST_FETCH1;
      end else begin
        case (st)
          ST_FETCH1: if (take) begin
            ir1 <= mem_rdata;
            pc  <= pc + WORD_STEP;
            st  <= ST_FETCH2;
          end
          ST_FETCH2: if (take) begin
            if (is_move) begin
              if (mv_blocked) begin
                pc <= pc + WORD_STEP;
                st <= ST_HALT;
              end else begin
                reg_we    <= 1'b1;
                reg_addr  <= mv_addr;
                reg_wdata <= mem_rdata;
                st        <= ST_FETCH1;
                if (mv_jump1)      pc <= loc[0] & ALIGN_MASK;
                else if (mv_jump2) pc <= loc[1] & ALIGN_MASK;
                else               pc <= pc + WORD_STEP;
              end
            end else if (is_wait) begin
              ir2 <= mem_rdata;
              pc  <= pc + WORD_STEP;
              st  <= ST_WAIT;
            end else begin
              pc <= pc + (skip_hit ? SKIP_STEP : WORD_STEP);
              st <= ST_FETCH1;
            end
          end
          ST_WAIT: if (wait_hit) st <= ST_FETCH1;
          default: ;
        endcase
      end
    end
  end

  // Requests only on alternate cycles
  assert_req_alternate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);

  // Fetch address moves only on a grant or a reload
  assert_addr_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!take && !redirect) |=> $stable(mem_addr));

  // Register write always follows a completed fetch
  assert_we_after_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> $past(take));

  // An unsatisfied wait keeps the bus quiet
  assert_wait_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WAIT && !wait_hit && !redirect) |=> (st == ST_WAIT && !mem_req));

  // Blitter gating holds a wait
  assert_wait_blit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WAIT && !ir2[15] && !blit_done && !redirect) |=> (st == ST_WAIT));

  // Reload restarts fetching at the aligned location
  assert_reload_R8: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |=> (st == ST_FETCH1 && mem_addr == $past(redirect_pc)));

  // Protected writes need the danger bit
  assert_protect_R10: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> (reg_addr >= PROT_LIMIT || $past(danger)));

endmodule

// File: rtl/beam_coproc.sv
module beam_coproc #(
  parameter int         ADDR_W     = 18,
  parameter logic [7:0] PROT_LIMIT = 8'h20,
  parameter logic [7:0] JMP1_WADDR = 8'h44,
  parameter logic [7:0] JMP2_WADDR = 8'h45
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_gnt,
  input  logic [15:0]       mem_rdata,
  output logic              reg_we,
  output logic [7:0]        reg_addr,
  output logic [15:0]       reg_wdata,
  input  logic [7:0]        beam_v,
  input  logic [8:0]        beam_h,
  input  logic              blit_done,
  input  logic              vblank,
  input  logic [1:0]        loc_we,
  input  logic [ADDR_W-1:0] loc_wdata,
  input  logic [1:0]        jmp_strobe,
  input  logic              ctl_we,
  input  logic              ctl_danger
);

  localparam int N_LOC = 2;

  logic [N_LOC-1:0][ADDR_W-1:0] loc;
  logic                         danger;
  logic [15:0]                  ir1, ir2;
  logic                         skip_hit, wait_hit;

  coproc_locs #(.ADDR_W(ADDR_W), .N_LOC(N_LOC)) u_locs (
    .clk(clk), .rst_n(rst_n), .loc_we(loc_we), .loc_wdata(loc_wdata),
    .ctl_we(ctl_we), .ctl_danger(ctl_danger), .loc_o(loc), .danger_o(danger)
  );

  // Skip decides on the word arriving now; wait re-checks the held word
  coproc_beam_cmp u_cmp_skip (
    .beam_v(beam_v), .beam_h(beam_h), .w1(ir1), .w2(mem_rdata),
    .blit_done(blit_done), .hit(skip_hit)
  );

  coproc_beam_cmp u_cmp_wait (
    .beam_v(beam_v), .beam_h(beam_h), .w1(ir1), .w2(ir2),
    .blit_done(blit_done), .hit(wait_hit)
  );

  coproc_seq #(
    .ADDR_W(ADDR_W), .PROT_LIMIT(PROT_LIMIT),
    .JMP1_WADDR(JMP1_WADDR), .JMP2_WADDR(JMP2_WADDR)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_gnt(mem_gnt), .mem_rdata(mem_rdata), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .loc(loc), .danger(danger),
    .vblank(vblank), .jmp_strobe(jmp_strobe), .blit_done(blit_done),
    .skip_hit(skip_hit), .wait_hit(wait_hit), .ir1_o(ir1), .ir2_o(ir2)
  );

  // Halted after reset until a reload arrives
  assert_idle_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!rst_n) && !vblank && jmp_strobe == 2'b00) |=> !mem_req);

endmodule

// File: tb/beam_coproc_test.sv
`timescale 1ns/1ps
module beam_coproc_test;
  localparam int AW = 18;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n, mem_req, mem_gnt, reg_we, blit_done, vblank, ctl_we, ctl_danger;
  logic [AW-1:0] mem_addr, loc_wdata;
  logic [15:0]   mem_rdata, reg_wdata;
  logic [7:0]    reg_addr, beam_v;
  logic [8:0]    beam_h;
  logic [1:0]    loc_we, jmp_strobe;

  logic [15:0] mem [0:1023];
  assign mem_rdata = mem[mem_addr[10:1]];

  beam_coproc uut (
    .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_gnt(mem_gnt), .mem_rdata(mem_rdata), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .beam_v(beam_v),
    .beam_h(beam_h), .blit_done(blit_done), .vblank(vblank),
    .loc_we(loc_we), .loc_wdata(loc_wdata), .jmp_strobe(jmp_strobe),
    .ctl_we(ctl_we), .ctl_danger(ctl_danger)
  );

  int n_checks = 0, n_fail = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Beam sweep and grant pattern, driven just after each rising edge
  bit       stall_mode = 0;
  logic [7:0] lfsr = 8'hA7;
  always @(posedge clk) begin
    #1;
    if (!rst_n) begin
      beam_h = 0; beam_v = 0;
    end else begin
      if (beam_h >= 9'd448) begin beam_h = 0; beam_v = beam_v + 8'd1; end
      else beam_h = beam_h + 9'd8;
    end
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    mem_gnt = stall_mode ? (lfsr[0] | lfsr[1]) : 1'b1;
  end

  // Behavioural reference model
  int          m_st;   // 0 stopped, 1 first word, 2 second word, 3 waiting
  bit          m_slot, m_we, m_dg, m_on;
  logic [17:0] m_pc, m_l1, m_l2;
  logic [15:0] m_ir1, m_ir2, m_w, m_wd;
  logic [7:0]  m_ra;

  function automatic bit reached_m(logic [7:0] v, logic [8:0] h, logic [15:0] a,
                                   logic [15:0] b, logic bd);
    int cur, tgt, vm, hm;
    vm  = int'(b[14:8]);
    hm  = int'(b[7:1]);
    cur = int'(v[7]) * 16384 + (int'(v[6:0]) & vm) * 128 + (int'(h[8:2]) & hm);
    tgt = int'(a[15]) * 16384 + (int'(a[14:8]) & vm) * 128 + (int'(a[7:1]) & hm);
    return (cur >= tgt) && (b[15] || bd);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_slot = 0; m_pc = 0; m_ir1 = 0; m_ir2 = 0; m_we = 0;
      m_ra = 0; m_wd = 0; m_l1 = 0; m_l2 = 0; m_dg = 0; m_on = 0;
    end else begin
      m_on = 1;
      m_we = 0;
      m_w  = mem[m_pc[10:1]];
      if (vblank || jmp_strobe[0]) begin m_pc = m_l1 & ~18'h1; m_st = 1; end
      else if (jmp_strobe[1])     begin m_pc = m_l2 & ~18'h1; m_st = 1; end
      else if (m_st == 1 && m_slot && mem_gnt) begin
        m_ir1 = m_w; m_pc = m_pc + 18'd2; m_st = 2;
      end else if (m_st == 2 && m_slot && mem_gnt) begin
        m_pc = m_pc + 18'd2;
        if (!m_ir1[0]) begin
          if (m_ir1[8:1] < 8'h20 && !m_dg) m_st = 0;
          else begin
            m_we = 1; m_ra = m_ir1[8:1]; m_wd = m_w; m_st = 1;
            if (m_ra == 8'h44) m_pc = m_l1 & ~18'h1;
            else if (m_ra == 8'h45) m_pc = m_l2 & ~18'h1;
          end
        end else if (!m_w[0]) begin
          m_ir2 = m_w; m_st = 3;
        end else begin
          if (reached_m(beam_v, beam_h, m_ir1, m_w, blit_done)) m_pc = m_pc + 18'd4;
          m_st = 1;
        end
      end else if (m_st == 3) begin
        if (reached_m(beam_v, beam_h, m_ir1, m_ir2, blit_done)) m_st = 1;
      end
      m_slot = !m_slot;
      if (loc_we[0]) m_l1 = loc_wdata;
      if (loc_we[1]) m_l2 = loc_wdata;
      if (ctl_we) m_dg = ctl_danger;
    end
  end

  // Per-cycle comparison and monitors
  logic [7:0]  log_a [$];
  logic [15:0] log_d [$];
  logic [7:0]  log_v [$];
  int  req_count = 0, alt_viol = 0;
  bit  prev_req = 0, first_pending = 0;
  logic [17:0] first_addr = '0;

  always @(negedge clk) begin
    bit exp_req;
    if (rst_n && m_on) begin
      exp_req = m_slot && (m_st == 1 || m_st == 2);
      check(mem_req === exp_req, "R2 request timing", 32'(mem_req), 32'(exp_req));
      if (exp_req) check(mem_addr === m_pc, "R2 fetch address", 32'(mem_addr), 32'(m_pc));
      check(reg_we === m_we, "R3 write strobe", 32'(reg_we), 32'(m_we));
      if (m_we) begin
        check(reg_addr === m_ra, "R3 write address", 32'(reg_addr), 32'(m_ra));
        check(reg_wdata === m_wd, "R3 write data", 32'(reg_wdata), 32'(m_wd));
      end
    end
    if (reg_we) begin log_a.push_back(reg_addr); log_d.push_back(reg_wdata); log_v.push_back(beam_v); end
    if (mem_req) req_count++;
    if (mem_req && prev_req) alt_viol++;
    prev_req = mem_req;
    if (first_pending && mem_req) begin first_addr = mem_addr; first_pending = 0; end
  end

  function automatic int find_a(logic [7:0] a);
    foreach (log_a[i]) if (log_a[i] == a) return i;
    return -1;
  endfunction

  task automatic put(input int byte_addr, input logic [15:0] w);
    mem[byte_addr >> 1] = w;
  endtask

  task automatic set_loc(input int idx, input logic [17:0] val);
    @(posedge clk); #1;
    loc_we = (idx == 1) ? 2'b01 : 2'b10; loc_wdata = val;
    @(posedge clk); #1;
    loc_we = 2'b00;
  endtask

  task automatic pulse(input logic [1:0] s, input logic vb);
    @(posedge clk); #1;
    jmp_strobe = s; vblank = vb;
    @(posedge clk); #1;
    jmp_strobe = 2'b00; vblank = 1'b0;
  endtask

  task automatic wait_log(input int n, input int max_cyc);
    for (int i = 0; i < max_cyc && log_a.size() < n; i++) @(posedge clk);
  endtask

  task automatic check_entry(input int idx, input logic [7:0] a, input logic [15:0] d,
                             input string tag);
    if (idx >= log_a.size()) check(0, tag, 32'(log_a.size()), 32'(idx + 1));
    else begin
      check(log_a[idx] == a, tag, 32'(log_a[idx]), 32'(a));
      check(log_d[idx] == d, tag, 32'(log_d[idx]), 32'(d));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int base, snap;
    for (int i = 0; i < 1024; i++) mem[i] = 16'h0000;
    // Program A at 0x100
    put(16'h100, 16'h0060); put(16'h102, 16'hA5A5);  // move 0x30
    put(16'h104, 16'h0062); put(16'h106, 16'h0001);  // move 0x31
    put(16'h108, 16'h1001); put(16'h10A, 16'hFFFE);  // wait V>=0x10
    put(16'h10C, 16'h0064); put(16'h10E, 16'h0BEE);  // move 0x32
    put(16'h110, 16'h0001); put(16'h112, 16'hFFFF);  // skip, always met
    put(16'h114, 16'h0066); put(16'h116, 16'hDEAD);  // move 0x33 (skipped)
    put(16'h118, 16'h8001); put(16'h11A, 16'h8001);  // skip on V7 only
    put(16'h11C, 16'h0068); put(16'h11E, 16'h5555);  // move 0x34
    put(16'h120, 16'h0001); put(16'h122, 16'h7FFE);  // wait for blitter
    put(16'h124, 16'h006A); put(16'h126, 16'h7777);  // move 0x35
    put(16'h128, 16'h0020); put(16'h12A, 16'h9999);  // move 0x10 protected
    put(16'h12C, 16'h006C); put(16'h12E, 16'h1111);  // move 0x36 never
    // Program B at 0x200
    put(16'h200, 16'h0020); put(16'h202, 16'h4242);  // move 0x10
    put(16'h204, 16'h0088); put(16'h206, 16'h0000);  // move to strobe 1
    // Programs C, D, E: one move, then an endless wait
    put(16'h300, 16'h006E); put(16'h302, 16'h3737);
    put(16'h304, 16'hFFFF); put(16'h306, 16'hFFFE);
    put(16'h380, 16'h0070); put(16'h382, 16'h3838);
    put(16'h384, 16'hFFFF); put(16'h386, 16'hFFFE);
    put(16'h3C0, 16'h0072); put(16'h3C2, 16'h3939);
    put(16'h3C4, 16'hFFFF); put(16'h3C6, 16'hFFFE);

    rst_n = 0; blit_done = 0; vblank = 0; ctl_we = 0; ctl_danger = 0;
    loc_we = 0; loc_wdata = 0; jmp_strobe = 0; mem_gnt = 1;
    beam_v = 0; beam_h = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(mem_req === 1'b0 && reg_we === 1'b0, "R1 reset outputs",
          32'({mem_req, reg_we}), 32'h0);
    @(posedge clk); #1 rst_n = 1;
    base = req_count;
    repeat (20) @(posedge clk);
    check(req_count == base, "R1 idle after reset", 32'(req_count - base), 32'h0);
    check(log_a.size() == 0, "R1 no write after reset", 32'(log_a.size()), 32'h0);

    set_loc(1, 18'h00101);
    set_loc(2, 18'h00200);
    stall_mode = 1;
    first_pending = 1;
    pulse(2'b01, 1'b0);
    wait_log(4, 4000);
    check(first_addr == 18'h100, "R2 reload clears bit 0", 32'(first_addr), 32'h100);
    check(alt_viol == 0, "R2 alternate requests", 32'(alt_viol), 32'h0);
    check_entry(0, 8'h30, 16'hA5A5, "R3 first move");
    check_entry(1, 8'h31, 16'h0001, "R3 second move");
    check_entry(2, 8'h32, 16'h0BEE, "R4 move after wait");
    if (log_v.size() > 2)
      check(log_v[2] >= 8'h10, "R4 wait ended at V>=0x10", 32'(log_v[2]), 32'h10);
    check(find_a(8'h33) < 0, "R7 met skip drops next move", 32'(find_a(8'h33)), 32'hFFFFFFFF);
    check_entry(3, 8'h34, 16'h5555, "R5 unmasked V7 keeps skip unmet");

    repeat (50) @(posedge clk);
    check(log_a.size() == 4, "R6 wait held by blitter", 32'(log_a.size()), 32'h4);
    #1 blit_done = 1;
    wait_log(5, 200);
    check_entry(4, 8'h35, 16'h7777, "R6 wait released by blitter");

    repeat (20) @(posedge clk);
    base = req_count;
    snap = log_a.size();
    repeat (60) @(posedge clk);
    check(req_count == base, "R10 stopped after protected move", 32'(req_count - base), 32'h0);
    check(log_a.size() == snap && find_a(8'h10) < 0, "R10 protected write dropped",
          32'(log_a.size()), 32'(snap));
    stall_mode = 0;

    @(posedge clk); #1 ctl_we = 1; ctl_danger = 1;
    @(posedge clk); #1 ctl_we = 0;
    set_loc(1, 18'h00300);
    pulse(2'b10, 1'b0);
    wait_log(8, 300);
    check_entry(5, 8'h10, 16'h4242, "R10 danger bit allows write");
    check_entry(6, 8'h44, 16'h0000, "R9 strobe move still written");
    check_entry(7, 8'h37, 16'h3737, "R9 strobe move reloads location 1");

    set_loc(1, 18'h00380);
    pulse(2'b00, 1'b1);
    wait_log(9, 300);
    check_entry(8, 8'h38, 16'h3838, "R8 vblank reloads location 1");

    set_loc(1, 18'h003C0);
    set_loc(2, 18'h00380);
    pulse(2'b11, 1'b0);
    wait_log(10, 300);
    check_entry(9, 8'h39, 16'h3939, "R8 strobe 1 over strobe 2");
    pulse(2'b10, 1'b1);
    wait_log(11, 300);
    check_entry(10, 8'h39, 16'h3939, "R8 vblank over strobe 2");

    repeat (10) @(posedge clk);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule